// File: doc/BRIEF.md
# Multichannel DMA Event Trigger and Queue Front End

This block sits at the front of a multichannel DMA controller. It collects trigger requests for every channel, records them as pending, picks one pending channel per cycle and pushes its channel number into one of several FIFO event queues. A later transfer-request stage pulls entries from the head of each queue with a valid/ready handshake. The block does not hold transfer parameters and does not move data.

A channel can be triggered in three ways. A hardware event line is recorded as pending but only goes forward while the channel's enable bit is set. A manual-set register write goes forward whatever the enable bit holds. A chained completion code names the channel directly. A small group of quick channels has no event line. Each quick channel fires when a bus write lands on its programmed trigger address and that quick channel is enabled. The channel identifier for quick channel k is NUM_CH+k. A routing field for each identifier picks its queue. Two error conditions raise sticky flags: a trigger that arrives while the channel is still pending, and a queue whose occupancy goes above its programmed threshold. Software clears both flags by writing ones.

Top module: `dq_event_queue`

## Requirements
- R1: A pulse on event line c sets that channel's pending state on the next clock edge. The channel is pushed on the edge after that only if bit c of the enable register (address 0x00) is 1. A disabled channel stays pending and is pushed once the enable bit is written to 1.
- R2: Writing a word with bit c set to address 0x01 queues channel c even when its enable bit is 0.
- R3: A chained completion with code c (chain_vld high, chain_code = c) queues channel c when c < NUM_CH. Codes of NUM_CH and above have no effect.
- R4: A bus write to the address held in quick trigger register k (address 0x08+k) queues identifier NUM_CH+k, but only while bit k of the quick-enable register (address 0x02) is 1.
- R5: Bits [QW-1:0] of the routing register for identifier i (address 0x10+i) select the queue that receives identifier i. After reset every identifier routes to queue 0.
- R6: Each queue delivers identifiers in push order. Its head (tr_valid and tr_id) holds steady while tr_ready is low, and an entry is removed on a cycle where both valid and ready are high.
- R7: When several identifiers are pending, the lowest-numbered one whose queue has room is pushed first, at most one per cycle. An identifier's pending state clears when it is pushed.
- R8: A trigger for an identifier that is already pending sets bit i of missed_err. The bit stays set until a 1 is written to bit i at address 0x03.
- R9: When a queue's occupancy is strictly greater than its threshold (address 0x30+q, reset value DEPTH), bit q of thr_err is set one cycle later. It stays set until a 1 is written to bit q at address 0x04.
- R10: An identifier whose queue is full is not pushed. It stays pending and is pushed once the queue has room.
- R11: After reset, no queue is valid and no error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Bus write address |
| wr_data | input | NID | Bus write data |
| hw_evt | input | NUM_CH | Hardware event pulses, one per channel |
| chain_vld | input | 1 | Chained completion strobe |
| chain_code | input | 6 | Chained completion code |
| tr_ready | input | NUM_Q | Downstream ready, one per queue |
| tr_valid | output | NUM_Q | Queue head valid, one per queue |
| tr_id | output | NUM_Q*IDW | Queue head identifier, IDW bits per queue |
| missed_err | output | NID | Sticky missed-trigger flags |
| thr_err | output | NUM_Q | Sticky threshold-exceeded flags |

## Verification
Properties are checked on every cycle for the following: the head of each queue stays stable while it is stalled, no push goes to a full queue, occupancy never goes above the depth, every push goes to the queue its routing field names, and an occupancy above the threshold is followed by the threshold flag. Other behaviour can only be shown by the bench's scenarios. These are the enable gating of hardware events and the bypass for manual sets, the valid range of chain codes, the address match for quick channels, lowest-first ordering, missed-trigger detection, and a held request that drains once a full queue has room. The bench covers them with sweeps over every channel, every chain code and every quick channel.

// File: rtl/dq_pkg.sv
package dq_pkg;
    localparam int          ADDR_W  = 8;
    localparam logic [7:0]  A_EN    = 8'h00;
    localparam logic [7:0]  A_SET   = 8'h01;
    localparam logic [7:0]  A_QEN   = 8'h02;
    localparam logic [7:0]  A_MCLR  = 8'h03;
    localparam logic [7:0]  A_TCLR  = 8'h04;
    localparam logic [7:0]  A_QADDR = 8'h08;
    localparam logic [7:0]  A_MAP   = 8'h10;
    localparam logic [7:0]  A_THR   = 8'h30;
endpackage

// File: rtl/dq_regs.sv
module dq_regs
    import dq_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int NUM_QCH = 4,
    parameter int NUM_Q   = 4,
    parameter int DEPTH   = 16,
    localparam int NID    = NUM_CH + NUM_QCH,
    localparam int QW     = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [NID-1:0]        wr_data,
    output logic [NUM_CH-1:0]     en,
    output logic [NID*QW-1:0]     map_flat,
    output logic [NUM_Q*CW-1:0]   thr_flat,
    output logic [NUM_CH-1:0]     set_vec,
    output logic [NID-1:0]        miss_clr,
    output logic [NUM_Q-1:0]      thr_clr,
    output logic [NUM_QCH-1:0]    quick_hit
);
    typedef struct packed {
        logic [NUM_CH-1:0]              en;
        logic [NUM_QCH-1:0]             qen;
        logic [NUM_QCH-1:0][ADDR_W-1:0] qaddr;
        logic [NID-1:0][QW-1:0]         map;
        logic [NUM_Q-1:0][CW-1:0]       thr;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == A_EN)  r_d.en  = wr_data[NUM_CH-1:0];
            if (wr_addr == A_QEN) r_d.qen = wr_data[NUM_QCH-1:0];
            for (int k = 0; k < NUM_QCH; k++)
                if (wr_addr == A_QADDR + ADDR_W'(k)) r_d.qaddr[k] = wr_data[ADDR_W-1:0];
            for (int i = 0; i < NID; i++)
                if (wr_addr == A_MAP + ADDR_W'(i)) r_d.map[i] = wr_data[QW-1:0];
            for (int q = 0; q < NUM_Q; q++)
                if (wr_addr == A_THR + ADDR_W'(q)) r_d.thr[q] = wr_data[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.en    <= '0;
            r_q.qen   <= '0;
            r_q.qaddr <= '0;
            r_q.map   <= '0;
            for (int q = 0; q < NUM_Q; q++) r_q.thr[q] <= CW'(DEPTH);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        set_vec  = (wr_en && wr_addr == A_SET)  ? wr_data[NUM_CH-1:0] : '0;
        miss_clr = (wr_en && wr_addr == A_MCLR) ? wr_data              : '0;
        thr_clr  = (wr_en && wr_addr == A_TCLR) ? wr_data[NUM_Q-1:0]   : '0;
        for (int k = 0; k < NUM_QCH; k++)
            quick_hit[k] = wr_en && r_q.qen[k] && (wr_addr == r_q.qaddr[k]);
    end

    assign en       = r_q.en;
    assign map_flat = r_q.map;
    assign thr_flat = r_q.thr;
endmodule

// File: rtl/dq_trig.sv
module dq_trig #(
    parameter int NUM_CH  = 16,
    parameter int NUM_QCH = 4,
    parameter int NUM_Q   = 4,
    localparam int NID    = NUM_CH + NUM_QCH,
    localparam int IDW    = $clog2(NID),
    localparam int QW     = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH-1:0]    hw_evt,
    input  logic [NUM_CH-1:0]    en,
    input  logic [NUM_CH-1:0]    set_vec,
    input  logic                 chain_vld,
    input  logic [5:0]           chain_code,
    input  logic [NUM_QCH-1:0]   quick_hit,
    input  logic [NID-1:0]       miss_clr,
    input  logic [NID*QW-1:0]    map_flat,
    input  logic [NUM_Q-1:0]     q_full,
    output logic                 push,
    output logic [QW-1:0]        push_q,
    output logic [IDW-1:0]       push_id,
    output logic [NID-1:0]       missed_err
);
    typedef struct packed {
        logic [NUM_CH-1:0]  evt;
        logic [NUM_CH-1:0]  man;
        logic [NUM_CH-1:0]  chn;
        logic [NUM_QCH-1:0] qck;
        logic [NID-1:0]     miss;
    } trig_t;

    trig_t s_d, s_q;

    logic [NUM_CH-1:0] chain_hit;
    logic [NID-1:0]    req, elig, clr, trig_any, pend_any;
    logic              found;
    logic [IDW-1:0]    pick;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++)
            chain_hit[c] = chain_vld && (chain_code == 6'(c));

        req      = {s_q.qck, (s_q.evt & en) | s_q.man | s_q.chn};
        pend_any = {s_q.qck, s_q.evt | s_q.man | s_q.chn};
        trig_any = {quick_hit, hw_evt | set_vec | chain_hit};

        for (int i = 0; i < NID; i++)
            elig[i] = req[i] && !q_full[map_flat[i*QW +: QW]];

        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < NID; i++) begin
            if (!found && elig[i]) begin
                found = 1'b1;
                pick  = IDW'(i);
            end
        end

        clr = '0;
        if (found) clr[pick] = 1'b1;

        s_d.evt  = (s_q.evt & ~clr[NUM_CH-1:0]) | hw_evt;
        s_d.man  = (s_q.man & ~clr[NUM_CH-1:0]) | set_vec;
        s_d.chn  = (s_q.chn & ~clr[NUM_CH-1:0]) | chain_hit;
        s_d.qck  = (s_q.qck & ~clr[NID-1:NUM_CH]) | quick_hit;
        s_d.miss = (s_q.miss & ~miss_clr) | (trig_any & pend_any & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign push       = found;
    assign push_id    = pick;
    assign push_q     = map_flat[pick*QW +: QW];
    assign missed_err = s_q.miss;
endmodule

// File: rtl/dq_fifo.sv
module dq_fifo #(
    parameter int W     = 5,
    parameter int DEPTH = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic          valid,
    output logic [W-1:0]  head,
    output logic          full,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_push, do_pop;

    always_comb begin
        f_d     = f_q;
        do_pop  = pop && (f_q.cnt != '0);
        do_push = push && (f_q.cnt != CW'(DEPTH));
        if (do_push) begin
            f_d.mem[f_q.wp] = push_data;
            f_d.wp = (f_q.wp == PW'(DEPTH - 1)) ? '0 : f_q.wp + 1'b1;
        end
        if (do_pop)
            f_d.rp = (f_q.rp == PW'(DEPTH - 1)) ? '0 : f_q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign valid = (f_q.cnt != '0);
    assign head  = f_q.mem[f_q.rp];
    assign full  = (f_q.cnt == CW'(DEPTH));
    assign count = f_q.cnt;
endmodule

// File: rtl/dq_event_queue.sv
module dq_event_queue
    import dq_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int NUM_QCH = 4,
    parameter int NUM_Q   = 4,
    parameter int DEPTH   = 16,
    localparam int NID    = NUM_CH + NUM_QCH,
    localparam int IDW    = $clog2(NID),
    localparam int QW     = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [NID-1:0]        wr_data,
    input  logic [NUM_CH-1:0]     hw_evt,
    input  logic                  chain_vld,
    input  logic [5:0]            chain_code,
    input  logic [NUM_Q-1:0]      tr_ready,
    output logic [NUM_Q-1:0]      tr_valid,
    output logic [NUM_Q*IDW-1:0]  tr_id,
    output logic [NID-1:0]        missed_err,
    output logic [NUM_Q-1:0]      thr_err
);
    logic [NUM_CH-1:0]   en, set_vec;
    logic [NID*QW-1:0]   map_flat;
    logic [NUM_Q*CW-1:0] thr_flat, cnt_flat;
    logic [NID-1:0]      miss_clr;
    logic [NUM_Q-1:0]    thr_clr, q_full;
    logic [NUM_QCH-1:0]  quick_hit;
    logic                push;
    logic [QW-1:0]       push_q;
    logic [IDW-1:0]      push_id;
    logic [NUM_Q-1:0]    thr_err_d, thr_err_q;

    dq_regs #(.NUM_CH(NUM_CH), .NUM_QCH(NUM_QCH), .NUM_Q(NUM_Q), .DEPTH(DEPTH)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .en(en), .map_flat(map_flat), .thr_flat(thr_flat), .set_vec(set_vec),
        .miss_clr(miss_clr), .thr_clr(thr_clr), .quick_hit(quick_hit)
    );

    dq_trig #(.NUM_CH(NUM_CH), .NUM_QCH(NUM_QCH), .NUM_Q(NUM_Q)) trig_i (
        .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .en(en), .set_vec(set_vec),
        .chain_vld(chain_vld), .chain_code(chain_code), .quick_hit(quick_hit),
        .miss_clr(miss_clr), .map_flat(map_flat), .q_full(q_full),
        .push(push), .push_q(push_q), .push_id(push_id), .missed_err(missed_err)
    );

    for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
        dq_fifo #(.W(IDW), .DEPTH(DEPTH)) fifo_i (
            .clk(clk), .rst_n(rst_n),
            .push(push && (push_q == QW'(q))), .push_data(push_id),
            .pop(tr_ready[q]),
            .valid(tr_valid[q]), .head(tr_id[q*IDW +: IDW]),
            .full(q_full[q]), .count(cnt_flat[q*CW +: CW])
        );
    end

    always_comb begin
        for (int q = 0; q < NUM_Q; q++)
            thr_err_d[q] = (thr_err_q[q] && !thr_clr[q]) ||
                           (cnt_flat[q*CW +: CW] > thr_flat[q*CW +: CW]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) thr_err_q <= '0;
        else        thr_err_q <= thr_err_d;
    end

    assign thr_err = thr_err_q;
endmodule

// File: rtl/dq_event_queue_chk.sv
module dq_event_queue_chk #(
    parameter int NID   = 20,
    parameter int IDW   = 5,
    parameter int QW    = 2,
    parameter int CW    = 5,
    parameter int NUM_Q = 4,
    parameter int DEPTH = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  push,
    input logic [QW-1:0]         push_q,
    input logic [IDW-1:0]        push_id,
    input logic [NUM_Q-1:0]      q_full,
    input logic [NUM_Q-1:0]      tr_valid,
    input logic [NUM_Q-1:0]      tr_ready,
    input logic [NUM_Q*IDW-1:0]  tr_id,
    input logic [NUM_Q*CW-1:0]   cnt_flat,
    input logic [NUM_Q*CW-1:0]   thr_flat,
    input logic [NUM_Q-1:0]      thr_err,
    input logic [NID*QW-1:0]     map_flat
);
    assert_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (map_flat[push_id*QW +: QW] == push_q));

    for (genvar q = 0; q < NUM_Q; q++) begin : g_chk
        assert_head_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (tr_valid[q] && !tr_ready[q]) |=> (tr_valid[q] && $stable(tr_id[q*IDW +: IDW])));

        assert_no_push_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (push && push_q == QW'(q)) |-> !q_full[q]);

        assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_flat[q*CW +: CW] <= CW'(DEPTH));

        assert_thr_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_flat[q*CW +: CW] > thr_flat[q*CW +: CW]) |=> thr_err[q]);
    end
endmodule

bind dq_event_queue dq_event_queue_chk #(
    .NID(NID), .IDW(IDW), .QW(QW), .CW(CW), .NUM_Q(NUM_Q), .DEPTH(DEPTH)
) chk_i (
    .clk(clk), .rst_n(rst_n), .push(push), .push_q(push_q), .push_id(push_id),
    .q_full(q_full), .tr_valid(tr_valid), .tr_ready(tr_ready), .tr_id(tr_id),
    .cnt_flat(cnt_flat), .thr_flat(thr_flat), .thr_err(thr_err), .map_flat(map_flat)
);

// File: tb/dq_event_queue_tb_top.sv
module dq_event_queue_tb_top;
    localparam int NUM_CH = 16, NUM_QCH = 4, NUM_Q = 4, DEPTH = 16;
    localparam int NID = NUM_CH + NUM_QCH, IDW = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [NID-1:0] wr_data = '0;
    logic [NUM_CH-1:0] hw_evt = '0;
    logic chain_vld = 1'b0;
    logic [5:0] chain_code = '0;
    logic [NUM_Q-1:0] tr_ready = '0;
    logic [NUM_Q-1:0] tr_valid;
    logic [NUM_Q*IDW-1:0] tr_id;
    logic [NID-1:0] missed_err;
    logic [NUM_Q-1:0] thr_err;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dq_event_queue dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hw_evt(hw_evt), .chain_vld(chain_vld), .chain_code(chain_code),
        .tr_ready(tr_ready), .tr_valid(tr_valid), .tr_id(tr_id),
        .missed_err(missed_err), .thr_err(thr_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'(a); wr_data = NID'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic hw_pulse(input int mask);
        @(negedge clk);
        hw_evt = NUM_CH'(mask);
        @(negedge clk);
        hw_evt = '0;
    endtask

    task automatic chain_pulse(input int code);
        @(negedge clk);
        chain_vld = 1'b1; chain_code = 6'(code);
        @(negedge clk);
        chain_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pop_chk(input int q, input int exp, input string req);
        int got;
        got = int'(tr_id[q*IDW +: IDW]);
        chk(tr_valid[q] && got == exp, req, tr_valid[q] ? got : -1, exp);
        tr_ready[q] = 1'b1;
        @(negedge clk);
        tr_ready[q] = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R11 reset state
        chk(tr_valid == 0, "R11 valid", int'(tr_valid), 0);
        chk(missed_err == 0 && thr_err == 0, "R11 errors", int'(missed_err), 0);

        // R1/R5 sweep: enabled hardware events, channel c to queue c%4
        wr(8'h00, 16'hFFFF);
        for (int c = 0; c < NUM_CH; c++) wr(8'h10 + c, c % 4);
        for (int c = 0; c < NUM_CH; c++) begin
            hw_pulse(1 << c);
            idle(1);
            chk(tr_valid == 4'(1 << (c % 4)), "R5 route", int'(tr_valid), 1 << (c % 4));
            pop_chk(c % 4, c, "R1 hw event queued");
        end

        // R2 sweep: manual set with enable off, reversed routing
        wr(8'h00, 0);
        for (int c = 0; c < NUM_CH; c++) wr(8'h10 + c, 3 - c % 4);
        for (int c = 0; c < NUM_CH; c++) begin
            wr(8'h01, 1 << c);
            idle(1);
            pop_chk(3 - c % 4, c, "R2 manual set");
        end

        // R3 sweep over every chain code
        for (int code = 0; code < 64; code++) begin
            chain_pulse(code);
            idle(1);
            if (code < NUM_CH) pop_chk(3 - code % 4, code, "R3 chain queued");
            else begin
                idle(2);
                chk(tr_valid == 0, "R3 chain code ignored", int'(tr_valid), 0);
            end
        end

        // R4 quick channels
        wr(8'h02, 4'hF);
        for (int k = 0; k < NUM_QCH; k++) begin
            wr(8'h08 + k, 8'h80 + k);
            wr(8'h10 + NUM_CH + k, k);
        end
        for (int k = 0; k < NUM_QCH; k++) begin
            wr(8'h80 + k, 0);
            idle(1);
            pop_chk(k, NUM_CH + k, "R4 quick trigger");
        end
        wr(8'h02, 0);
        wr(8'h80, 0);
        idle(3);
        chk(tr_valid == 0, "R4 quick disabled", int'(tr_valid), 0);
        wr(8'h02, 4'hF);

        // R1 enable gating: pending while disabled, queued when enabled
        hw_pulse(1 << 5);
        idle(4);
        chk(tr_valid == 0, "R1 disabled held", int'(tr_valid), 0);
        wr(8'h00, 1 << 5);
        idle(1);
        pop_chk(2, 5, "R1 queued on enable");

        // R7 lowest first, one per cycle, pending cleared
        for (int c = 0; c < NUM_CH; c++) wr(8'h10 + c, 0);
        wr(8'h00, 16'hFFFF);
        hw_pulse(16'hA5A5);
        idle(10);
        for (int c = 0; c < NUM_CH; c++)
            if ((16'hA5A5 >> c) & 1) pop_chk(0, c, "R7 priority order");
        idle(4);
        chk(tr_valid == 0, "R7 pending cleared", int'(tr_valid), 0);
        chk(missed_err == 0, "R8 no false miss", int'(missed_err), 0);

        // R8 missed event
        wr(8'h00, 0);
        hw_pulse(1 << 3);
        hw_pulse(1 << 3);
        idle(1);
        chk(missed_err == NID'(1 << 3), "R8 missed set", int'(missed_err), 1 << 3);
        idle(3);
        chk(missed_err == NID'(1 << 3), "R8 missed sticky", int'(missed_err), 1 << 3);
        wr(8'h03, 1 << 3);
        chk(missed_err == 0, "R8 missed clear", int'(missed_err), 0);
        wr(8'h00, 1 << 3);
        idle(1);
        pop_chk(0, 3, "R8 drained");

        // R9 threshold on queue 1
        for (int c = 0; c < 3; c++) wr(8'h10 + c, 1);
        wr(8'h31, 2);
        wr(8'h01, 1);
        wr(8'h01, 2);
        idle(3);
        chk(thr_err == 0, "R9 at threshold", int'(thr_err), 0);
        wr(8'h01, 4);
        idle(2);
        chk(thr_err == 4'b0010, "R9 above threshold", int'(thr_err), 2);
        for (int c = 0; c < 3; c++) pop_chk(1, c, "R6 fifo order");
        wr(8'h04, 2);
        chk(thr_err == 0, "R9 clear", int'(thr_err), 0);
        wr(8'h31, DEPTH);

        // R10 full queue holds request
        for (int c = 0; c < NUM_CH; c++) wr(8'h10 + c, 2);
        wr(8'h10 + NUM_CH, 2);
        wr(8'h01, 16'hFFFF);
        idle(20);
        wr(8'h80, 0);
        idle(5);
        chk(thr_err == 0, "R9 full not above depth", int'(thr_err), 0);
        for (int c = 0; c < NUM_CH; c++) pop_chk(2, c, "R10 full queue order");
        idle(1);
        pop_chk(2, NUM_CH, "R10 held request pushed");
        idle(3);
        chk(tr_valid == 0, "R6 empty after drain", int'(tr_valid), 0);
        chk(missed_err == 0, "R8 no stray miss", int'(missed_err), 0);

        finish_run();
    end
endmodule